// File: doc/BRIEF.md
# PS/2 Port Host Register Front-End

This block is the register-side front-end of a host controller for a PS/2-style keyboard or mouse port. A processor reaches it over a simple word-addressed 32-bit register bus. Through that bus the processor sets an interrupt configuration and a clock divisor, reads the bytes the device has sent, sends bytes to the device, and reads a fixed identification window. The line serializer, parity handling and the device protocol are outside the block. The block meets the serializer at two points: a valid/ready input for bytes received from the device, and a one-cycle strobe with a byte bus for bytes the host sends.

Received bytes wait in a single-entry holder. While the holder is full, the byte is "pending". A data-register read then takes the byte, records it as the most recent value and frees the holder. A data read with nothing pending returns the most recent value again. A single registered level interrupt combines the pending flag, gated by a receive-enable bit, with a transmit-enable bit that raises the line on its own.

Top module: `kbd_port_regs`

## Requirements
- R1: After reset the control, divisor, last-byte and pending state are zero, `irq` is low, `rx_ready` is high, `tx_strobe` and `bus_err` are low.
- R2: The control register (word 0) and the divisor register (word 3) read back the full 32-bit value last written to them.
- R3: A status read (word 1) returns 0x10 while a byte is pending and 0 otherwise.
- R4: An interrupt-status read (word 4) returns 2 plus the pending flag in bit 0.
- R5: `rx_ready` is high exactly when the holder is empty. A byte presented with `rx_valid` while `rx_ready` is high is captured and makes the byte pending.
- R6: A data read (word 2) while a byte is pending returns that byte in bits 7:0 and clears pending, so that `rx_ready` goes high again.
- R7: A data read with nothing pending returns the byte returned by the last popping read, or 0 if no byte has been popped since reset, and changes no state.
- R8: A write to word 2 pulses `tx_strobe` for one cycle, in the cycle after the write, with `tx_byte` equal to bits 7:0 of the written value.
- R9: `irq` equals (pending AND control bit 4) OR control bit 3. It is registered, so it follows a change of pending or control one cycle later.
- R10: Reads of words 0x3F8 through 0x3FF return one byte each, in the order 0x50, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1, zero-extended.
- R11: Writes to words 1, 4 and the identification words change nothing that can be read back.
- R12: A read of any other word returns 0 and raises `bus_err` for exactly the one cycle after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word address (byte offset shifted right by 2) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read access |
| bus_err | output | 1 | Unmapped-read flag, one cycle |
| rx_valid | input | 1 | Received byte offered |
| rx_byte | input | 8 | Received byte |
| rx_ready | output | 1 | Holder empty, byte will be taken |
| tx_strobe | output | 1 | One-cycle send strobe |
| tx_byte | output | 8 | Byte to send |
| irq | output | 1 | Level interrupt |

## Verification
On every cycle the assertions check the following: a byte is captured on a handshake, a pop empties the holder, the held byte stays put while it waits, the interrupt follows its two causes one cycle late, and data writes and unmapped reads produce their one-cycle pulses. Read values can only be shown by the bench's scenarios. These cover the identification bytes, the status encodings, the last-byte replay and the ignored writes. The bench sweeps all 256 received byte values, every combination of the interrupt inputs, and every unmapped word.

// File: rtl/kbd_port_pkg.sv
package kbd_port_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned WADDR_W  = 10;
  localparam int unsigned ID_WORDS = 8;
  localparam int unsigned ID_SEL_W = $clog2(ID_WORDS);
  localparam logic [WADDR_W-1:0] ID_BASE_W = 10'h3F8;

  localparam logic [WADDR_W-1:0] W_CTRL   = 10'd0;
  localparam logic [WADDR_W-1:0] W_STAT   = 10'd1;
  localparam logic [WADDR_W-1:0] W_DATA   = 10'd2;
  localparam logic [WADDR_W-1:0] W_CLKDIV = 10'd3;
  localparam logic [WADDR_W-1:0] W_ISTAT  = 10'd4;

  localparam int unsigned CTL_TXEN_BIT = 3;
  localparam int unsigned CTL_RXEN_BIT = 4;
  localparam logic [DATA_W-1:0] STAT_PEND_VAL = 32'h10;

  // One identification byte per word in the window
  function automatic logic [BYTE_W-1:0] id_byte(input logic [ID_SEL_W-1:0] sel);
    case (sel)
      3'd0: id_byte = 8'h50;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h04;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

  // Interrupt level from its causes
  function automatic logic irq_level(input logic pend, input logic rx_en, input logic tx_en);
    irq_level = (pend & rx_en) | tx_en;
  endfunction

  function automatic logic [DATA_W-1:0] zext_byte(input logic [BYTE_W-1:0] b);
    zext_byte = {{(DATA_W-BYTE_W){1'b0}}, b};
  endfunction
endpackage

// File: rtl/kbd_rx_holder.sv
module kbd_rx_holder #(
  parameter int unsigned BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [BW-1:0] in_byte,
  output logic          in_ready,
  input  logic          pop,
  output logic          pending,
  output logic [BW-1:0] held
);
  logic          full_q;
  logic [BW-1:0] data_q;
  logic          take;

  assign in_ready = ~full_q;
  assign take     = in_valid & ~full_q;
  assign pending  = full_q;
  assign held     = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (take) begin
      full_q <= 1'b1;
      data_q <= in_byte;
    end else if (pop) begin
      full_q <= 1'b0;
    end
  end

  AST_CAPTURE_SETS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (pending && held == $past(in_byte))); // R5
  AST_POP_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && pending) |=> in_ready); // R6
  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !pop) |=> (pending && $stable(held))); // R5
endmodule

// File: rtl/kbd_irq_gen.sv
module kbd_irq_gen
  import kbd_port_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pending,
  input  logic rx_en,
  input  logic tx_en,
  output logic irq
);
  logic irq_q;
  assign irq = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_level(pending, rx_en, tx_en);
  end

  AST_TX_FORCES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |=> irq); // R9
  AST_RX_GATED_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && rx_en) |=> irq); // R9
  AST_NO_CAUSE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !(pending && rx_en)) |=> !irq); // R9
endmodule

// File: rtl/kbd_port_regs.sv
module kbd_port_regs
  import kbd_port_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [WADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               bus_err,
  input  logic               rx_valid,
  input  logic [BYTE_W-1:0]  rx_byte,
  output logic               rx_ready,
  output logic               tx_strobe,
  output logic [BYTE_W-1:0]  tx_byte,
  output logic               irq
);
  logic [DATA_W-1:0] ctrl_q, clkdiv_q, rdata_q;
  logic [BYTE_W-1:0] last_q, tx_byte_q, held;
  logic              err_q, tx_stb_q, pending;
  logic              rd_acc, wr_acc, in_id, unmapped;
  logic              pop_evt, txwr_evt, unmapped_rd_evt;
  logic [DATA_W-1:0] rd_val;

  assign rd_acc = bus_sel & ~bus_wr;
  assign wr_acc = bus_sel &  bus_wr;
  assign in_id  = (bus_addr >= ID_BASE_W);

  // Read decode
  always_comb begin
    rd_val   = '0;
    unmapped = 1'b0;
    if (in_id) begin
      rd_val = zext_byte(id_byte(bus_addr[ID_SEL_W-1:0]));
    end else begin
      case (bus_addr)
        W_CTRL:   rd_val = ctrl_q;
        W_STAT:   rd_val = pending ? STAT_PEND_VAL : '0;
        W_DATA:   rd_val = zext_byte(pending ? held : last_q);
        W_CLKDIV: rd_val = clkdiv_q;
        W_ISTAT:  rd_val = {{(DATA_W-2){1'b0}}, 1'b1, pending};
        default:  unmapped = 1'b1;
      endcase
    end
  end

  assign pop_evt         = rd_acc & ~in_id & (bus_addr == W_DATA) & pending;
  assign txwr_evt        = wr_acc & ~in_id & (bus_addr == W_DATA);
  assign unmapped_rd_evt = rd_acc & unmapped;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      clkdiv_q  <= '0;
      last_q    <= '0;
      rdata_q   <= '0;
      err_q     <= 1'b0;
      tx_stb_q  <= 1'b0;
      tx_byte_q <= '0;
    end else begin
      err_q    <= unmapped_rd_evt;
      tx_stb_q <= txwr_evt;
      if (rd_acc) rdata_q <= rd_val;
      if (pop_evt) last_q <= held;
      if (txwr_evt) tx_byte_q <= bus_wdata[BYTE_W-1:0];
      if (wr_acc && !in_id && bus_addr == W_CTRL)   ctrl_q   <= bus_wdata;
      if (wr_acc && !in_id && bus_addr == W_CLKDIV) clkdiv_q <= bus_wdata;
    end
  end

  assign bus_rdata = rdata_q;
  assign bus_err   = err_q;
  assign tx_strobe = tx_stb_q;
  assign tx_byte   = tx_byte_q;

  kbd_rx_holder #(.BW(BYTE_W)) u_holder (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (rx_valid),
    .in_byte  (rx_byte),
    .in_ready (rx_ready),
    .pop      (pop_evt),
    .pending  (pending),
    .held     (held)
  );

  kbd_irq_gen u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .pending (pending),
    .rx_en   (ctrl_q[CTL_RXEN_BIT]),
    .tx_en   (ctrl_q[CTL_TXEN_BIT]),
    .irq     (irq)
  );

  AST_TX_STROBE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    txwr_evt |=> (tx_strobe && tx_byte == $past(bus_wdata[BYTE_W-1:0]))); // R8
  AST_TX_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !txwr_evt |=> !tx_strobe); // R8
  AST_ERR_ON_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped_rd_evt |=> (bus_err && bus_rdata == '0)); // R12
  AST_POP_LATCHES_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    pop_evt |=> (bus_rdata == zext_byte(last_q))); // R6
endmodule

// File: tb/kbd_port_regs_bench.sv
`timescale 1ns/1ps
module kbd_port_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [9:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic        rx_valid;
  logic [7:0]  rx_byte;
  logic        rx_ready, tx_strobe, irq;
  logic [7:0]  tx_byte;

  int n_run  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  kbd_port_regs u_kbd_port_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_ready(rx_ready), .tx_strobe(tx_strobe), .tx_byte(tx_byte), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata; e = bus_err;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  function automatic logic [7:0] id_exp(input int k);
    logic [7:0] t [8] = '{8'h50, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    return t[k];
  endfunction

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic        e;
    logic [7:0]  last;
    bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    rx_valid = 0; rx_byte = '0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'd0);
    check("R1 rx_ready", {31'b0, rx_ready}, 32'd1);
    check("R1 tx_strobe", {31'b0, tx_strobe}, 32'd0);
    check("R1 bus_err", {31'b0, bus_err}, 32'd0);
    rd(10'd0, d, e); check("R1 ctrl", d, 32'd0);
    rd(10'd3, d, e); check("R1 clkdiv", d, 32'd0);
    rd(10'd2, d, e); check("R1 data R7", d, 32'd0);

    // R2 read-back
    for (int i = 0; i < 32; i++) begin
      wr(10'd3, 32'h1 << i); rd(10'd3, d, e); check("R2 clkdiv", d, 32'h1 << i);
    end
    wr(10'd0, 32'hA5A5_0000); rd(10'd0, d, e); check("R2 ctrl", d, 32'hA5A5_0000);
    wr(10'd0, 32'h0);

    // R3/R4 empty
    rd(10'd1, d, e); check("R3 status empty", d, 32'h0);
    rd(10'd4, d, e); check("R4 istat empty", d, 32'h2);

    // R5/R6/R7: every byte value
    last = 8'h00;
    for (int b = 0; b < 256; b++) begin
      check("R5 ready before", {31'b0, rx_ready}, 32'd1);
      push(8'(b));
      check("R5 ready while full", {31'b0, rx_ready}, 32'd0);
      push(8'(~b));  // offered while full: must be refused
      rd(10'd1, d, e); check("R3 status pending", d, 32'h10);
      rd(10'd4, d, e); check("R4 istat pending", d, 32'h3);
      rd(10'd2, d, e); check("R6 pop value", d, 32'(b));
      check("R6 ready after pop", {31'b0, rx_ready}, 32'd1);
      last = 8'(b);
      rd(10'd2, d, e); check("R7 replay", d, {24'b0, last});
      rd(10'd1, d, e); check("R7 status stays empty", d, 32'h0);
    end

    // R8 transmit
    for (int b = 0; b < 256; b += 17) begin
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = 10'd2; bus_wdata = 32'hFFFF_FF00 | 32'(b);
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
      check("R8 strobe", {31'b0, tx_strobe}, 32'd1);
      check("R8 byte", {24'b0, tx_byte}, 32'(b));
      @(negedge clk);
      check("R8 strobe one cycle", {31'b0, tx_strobe}, 32'd0);
    end
    rd(10'd1, d, e); check("R8 no pending from write", d, 32'h0);

    // R9 interrupt combinations
    for (int rxe = 0; rxe < 2; rxe++)
      for (int txe = 0; txe < 2; txe++)
        for (int p = 0; p < 2; p++) begin
          if (p == 1 && rx_ready) push(8'h3C);
          if (p == 0 && !rx_ready) rd(10'd2, d, e);
          wr(10'd0, (32'(rxe) << 4) | (32'(txe) << 3));
          @(negedge clk);
          check($sformatf("R9 irq rx%0d tx%0d p%0d", rxe, txe, p),
                {31'b0, irq}, 32'((p & rxe) | txe));
        end
    // R9 pending drop follows one cycle later
    wr(10'd0, 32'h10);
    if (rx_ready) push(8'h11);
    @(negedge clk);
    check("R9 irq pending", {31'b0, irq}, 32'd1);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = 10'd2;
    @(negedge clk); bus_sel = 0;
    check("R9 irq one cycle late", {31'b0, irq}, 32'd1);
    @(negedge clk);
    check("R9 irq dropped", {31'b0, irq}, 32'd0);
    wr(10'd0, 32'h0);

    // R10 identification
    for (int k = 0; k < 8; k++) begin
      rd(10'h3F8 + 10'(k), d, e);
      check("R10 id", d, {24'b0, id_exp(k)});
      check("R10 id no err", {31'b0, e}, 32'd0);
    end

    // R11 ignored writes
    wr(10'd0, 32'h0000_1234); wr(10'd3, 32'h0000_5678);
    wr(10'd1, 32'hFFFF_FFFF); wr(10'd4, 32'hFFFF_FFFF);
    for (int k = 0; k < 8; k++) wr(10'h3F8 + 10'(k), 32'hFFFF_FFFF);
    rd(10'd1, d, e); check("R11 status", d, 32'h0);
    rd(10'd4, d, e); check("R11 istat", d, 32'h2);
    rd(10'd0, d, e); check("R11 ctrl", d, 32'h0000_1234);
    rd(10'd3, d, e); check("R11 clkdiv", d, 32'h0000_5678);
    check("R11 irq", {31'b0, irq}, 32'd0);
    for (int k = 0; k < 8; k++) begin
      rd(10'h3F8 + 10'(k), d, e); check("R11 id", d, {24'b0, id_exp(k)});
    end

    // R12 unmapped sweep
    for (int w = 5; w < 10'h3F8; w++) begin
      rd(10'(w), d, e);
      check("R12 data", d, 32'h0);
      check("R12 err", {31'b0, e}, 32'd1);
    end
    @(negedge clk);
    check("R12 err one cycle", {31'b0, bus_err}, 32'd0);
    rd(10'd0, d, e); check("R12 mapped no err", {31'b0, e}, 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule